// File: doc/BRIEF.md
# Event-Locked Waveform Player with Serial DAC Output

This block replays stored waveform samples through a serial DAC link. Two playback channels run side by side. The ECG channel holds two stored segments, an atrial wave and a ventricular wave. The impedance channel holds one segment. A segment is not played in a loop. It starts when the chamber event that owns it arrives from the pacing sequencer, so the stored waves stay in phase with the pacing.

Each channel has one current sample. On every sample-rate tick the block captures both current samples and sends them as two serial frames: the ECG frame on the ECG chip select, then the impedance frame on the impedance chip select. A channel with no segment playing sends its resting level, which is stored at table address 0. Sample tables are computed in logic, so the contents can be predicted from the address.

Top module: `wsd_top`

## Requirements
- R1: While reset is asserted and after its release with no tick, both chip selects are high (1), SCLK is low (0) and MOSI is low (0).
- R2: Each frame drives its chip select low for exactly 16 SCLK rising edges. Data goes out MSB first in SPI mode 0: SCLK idles low and MOSI changes only while SCLK is low.
- R3: Each tick produces exactly two frames. The ECG word goes out on `cs_ecg_no` first, then the impedance word on `cs_imp_no`. The two chip selects are never low together.
- R4: A channel with no segment playing sends its address-0 resting word. This word is 16'h0800 for ECG and 16'h0400 for impedance.
- R5: A table word at address a>0 is {tag, a[11:0]}. The tag is 4'h1 for ECG and 4'h2 for impedance.
- R6: After an atrial event, the ECG channel sends addresses 1..SEG_LEN_ECG, one per tick starting at the next tick, and then returns to its resting word.
- R7: After a right-ventricular event, the ECG channel sends addresses SEG_LEN_ECG+1..2*SEG_LEN_ECG, one per tick, and then returns to its resting word.
- R8: After a left-ventricular event, the impedance channel sends addresses 1..SEG_LEN_IMP, one per tick, and then returns to its resting word.
- R9: An event that arrives while its segment is still playing restarts that segment from its first sample.
- R10: When atrial and right-ventricular events arrive in the same cycle, the ventricular segment is played.
- R11: An event in the same cycle as a tick does not change the word that tick sends. The segment's first sample goes out on the following tick.
- R12: An event for one channel leaves the other channel's sample sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample-rate pulse |
| ra_evt_i | input | 1 | Atrial event strobe |
| rv_evt_i | input | 1 | Right-ventricular event strobe |
| lv_evt_i | input | 1 | Left-ventricular event strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_ecg_no | output | 1 | ECG DAC chip select, active low |
| cs_imp_no | output | 1 | Impedance DAC chip select, active low |

## Verification
The assertions assume that ticks come far enough apart for both frames of one tick to finish before the next tick arrives. Two frames take about 33*SCLK_HALF cycles each, plus gaps. They also assume that event strobes are single-cycle pulses. The bench spaces ticks 150 cycles apart, which is well above the 132 cycles two frames need with default parameters. It drives each event as a one-cycle pulse, either between ticks or exactly on a tick for the R11 case. A monitor decodes every frame from the pins and checks it against words predicted by a bench model of segment playback.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  localparam int DAC_W = 16;
  typedef logic [DAC_W-1:0] dac_word_t;
  typedef enum logic {CH_ECG = 1'b0, CH_IMP = 1'b1} chan_e;
endpackage

// File: rtl/wsd_rom.sv
module wsd_rom
  import wsd_pkg::*;
#(
  parameter int        AW   = 5,
  parameter logic [3:0] TAG = 4'h1,
  parameter dac_word_t BASE = 16'h0800
) (
  input  logic [AW-1:0] addr_i,
  output dac_word_t     data_o
);
  // computed table: resting level at 0, tagged address elsewhere (R4, R5)
  always_comb begin
    if (addr_i == '0) data_o = BASE;
    else              data_o = {TAG, 12'(addr_i)};
  end
endmodule

// File: rtl/wsd_player.sv
module wsd_player
  import wsd_pkg::*;
#(
  parameter int         NSEG    = 2,
  parameter int         SEG_LEN = 8,
  parameter logic [3:0] TAG     = 4'h1,
  parameter dac_word_t  BASE    = 16'h0800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NSEG-1:0] evt_i,
  output dac_word_t       sample_o
);
  localparam int AW = $clog2(NSEG * SEG_LEN + 1);
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [AW-1:0] addr_q;
  logic [SW-1:0] seg_q;
  logic          act_q;
  logic          any_evt;
  int            sel;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] end_addr;

  // highest index wins (R10)
  always_comb begin
    sel = 0;
    for (int k = 0; k < NSEG; k++) begin
      if (evt_i[k]) sel = k;
    end
  end

  assign any_evt    = |evt_i;
  assign start_addr = AW'(1 + sel * SEG_LEN);
  assign end_addr   = AW'((int'(seg_q) + 1) * SEG_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      seg_q  <= '0;
      act_q  <= 1'b0;
    end else if (any_evt) begin
      addr_q <= start_addr;
      seg_q  <= SW'(sel);
      act_q  <= 1'b1;
    end else if (tick_i && act_q) begin
      if (addr_q == end_addr) begin
        addr_q <= '0;
        act_q  <= 1'b0;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  wsd_rom #(.AW(AW), .TAG(TAG), .BASE(BASE)) rom_i (
    .addr_i (addr_q),
    .data_o (sample_o)
  );

  a_r6_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (addr_q >= AW'(1)) && (addr_q <= AW'(NSEG * SEG_LEN)));
  a_r4_idle_at_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> addr_q == '0);
  a_r9_restart_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[NSEG-1] |=> addr_q == AW'(1 + (NSEG - 1) * SEG_LEN));
  a_r6_lowest_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == NSEG'(1)) |=> addr_q == AW'(1));
endmodule

// File: rtl/wsd_spi_tx.sv
module wsd_spi_tx
  import wsd_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  dac_word_t data_i,
  output logic      busy_o,
  output logic      sclk_o,
  output logic      mosi_o,
  output logic      cs_no
);
  localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(DAC_W);

  logic            busy_q;
  logic            sclk_q;
  logic [DW-1:0]   div_q;
  logic [BW-1:0]   bit_q;
  dac_word_t       sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        sh_q   <= data_i;
      end
    end else if (div_q == DW'(SCLK_HALF - 1)) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == BW'(DAC_W - 1)) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[DAC_W-2:0], 1'b0};
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & sh_q[DAC_W-1];
  assign cs_no  = ~busy_q;

  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_mosi_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  a_r2_cs_end_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $fell(sclk_o));
endmodule

// File: rtl/wsd_top.sv
module wsd_top
  import wsd_pkg::*;
#(
  parameter int SEG_LEN_ECG = 8,
  parameter int SEG_LEN_IMP = 12,
  parameter int SCLK_HALF   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ra_evt_i,
  input  logic rv_evt_i,
  input  logic lv_evt_i,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_ecg_no,
  output logic cs_imp_no
);
  dac_word_t ecg_smp, imp_smp;
  dac_word_t ecg_word_q, imp_word_q;
  logic      ecg_pend_q, imp_pend_q;
  chan_e     sel_q;
  logic      busy, start, cs_n;
  dac_word_t tx_word;

  wsd_player #(.NSEG(2), .SEG_LEN(SEG_LEN_ECG), .TAG(4'h1), .BASE(16'h0800)) ecg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .evt_i    ({rv_evt_i, ra_evt_i}),
    .sample_o (ecg_smp)
  );

  wsd_player #(.NSEG(1), .SEG_LEN(SEG_LEN_IMP), .TAG(4'h2), .BASE(16'h0400)) imp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .evt_i    (lv_evt_i),
    .sample_o (imp_smp)
  );

  // ECG frame leaves first (R3)
  assign start   = !busy && (ecg_pend_q || imp_pend_q);
  assign tx_word = ecg_pend_q ? ecg_word_q : imp_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecg_word_q <= '0;
      imp_word_q <= '0;
      ecg_pend_q <= 1'b0;
      imp_pend_q <= 1'b0;
      sel_q      <= CH_ECG;
    end else if (tick_i) begin
      ecg_word_q <= ecg_smp;
      imp_word_q <= imp_smp;
      ecg_pend_q <= 1'b1;
      imp_pend_q <= 1'b1;
    end else if (start) begin
      if (ecg_pend_q) begin
        ecg_pend_q <= 1'b0;
        sel_q      <= CH_ECG;
      end else begin
        imp_pend_q <= 1'b0;
        sel_q      <= CH_IMP;
      end
    end
  end

  wsd_spi_tx #(.SCLK_HALF(SCLK_HALF)) spi_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (tx_word),
    .busy_o  (busy),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_n)
  );

  assign cs_ecg_no = cs_n | (sel_q != CH_ECG);
  assign cs_imp_no = cs_n | (sel_q != CH_IMP);

  a_r3_tick_when_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> !busy && !ecg_pend_q && !imp_pend_q);
  a_r3_one_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ecg_no || cs_imp_no);
  a_r3_imp_after_ecg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_imp_no) |-> !ecg_pend_q);
endmodule

// File: tb/wsd_top_tb_top.sv
module wsd_top_tb_top;
  localparam int ECG_LEN = 8;
  localparam int IMP_LEN = 12;
  localparam int GAP     = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ra = 1'b0, rv = 1'b0, lv = 1'b0;
  logic sclk, mosi, cs_ecg_n, cs_imp_n;

  always #2.5 clk = ~clk;

  wsd_top #(.SEG_LEN_ECG(ECG_LEN), .SEG_LEN_IMP(IMP_LEN), .SCLK_HALF(2)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .ra_evt_i  (ra),
    .rv_evt_i  (rv),
    .lv_evt_i  (lv),
    .sclk_o    (sclk),
    .mosi_o    (mosi),
    .cs_ecg_no (cs_ecg_n),
    .cs_imp_no (cs_imp_n)
  );

  typedef struct {
    logic [15:0] word;
    bit          imp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model of playback
  int  ea = 0, eseg = 0, ia = 0;
  bit  eact = 0, iact = 0;

  function automatic logic [15:0] ecg_w(int a);
    return (a == 0) ? 16'h0800 : (16'h1000 | 16'(a));
  endfunction
  function automatic logic [15:0] imp_w(int a);
    return (a == 0) ? 16'h0400 : (16'h2000 | 16'(a));
  endfunction

  task automatic model_evt(bit e_ra, bit e_rv, bit e_lv);
    if (e_rv) begin ea = ECG_LEN + 1; eseg = 1; eact = 1; end
    else if (e_ra) begin ea = 1; eseg = 0; eact = 1; end
    if (e_lv) begin ia = 1; iact = 1; end
  endtask

  task automatic check(bit cond, string tag, string what, int act, int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_evt(bit e_ra, bit e_rv, bit e_lv);
    @(negedge clk);
    ra = e_ra; rv = e_rv; lv = e_lv;
    @(negedge clk);
    ra = 0; rv = 0; lv = 0;
    model_evt(e_ra, e_rv, e_lv);
    repeat (5) @(negedge clk);
  endtask

  // tick with optional simultaneous events (R11)
  task automatic do_tick(string tag, bit e_ra = 0, bit e_rv = 0, bit e_lv = 0);
    exp_t e;
    @(negedge clk);
    tick = 1; ra = e_ra; rv = e_rv; lv = e_lv;
    e.word = ecg_w(ea); e.imp = 0; e.tag = tag; exp_q.push_back(e);
    e.word = imp_w(ia); e.imp = 1; e.tag = tag; exp_q.push_back(e);
    if (e_ra || e_rv) model_evt(e_ra, e_rv, 0);
    else if (eact) begin
      if (ea == (eseg + 1) * ECG_LEN) begin ea = 0; eact = 0; end else ea++;
    end
    if (e_lv) model_evt(0, 0, 1);
    else if (iact) begin
      if (ia == IMP_LEN) begin ia = 0; iact = 0; end else ia++;
    end
    @(negedge clk);
    tick = 0; ra = 0; rv = 0; lv = 0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  // monitor: decode frames from pins
  logic        p_sclk = 0, p_ce = 1, p_ci = 1;
  logic [15:0] sh = '0;
  int          nbit = 0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (!cs_ecg_n && !cs_imp_n) check(0, "R3", "both cs low", 0, 1);
      if ((p_ce && !cs_ecg_n) || (p_ci && !cs_imp_n)) begin
        sh = '0; nbit = 0;
      end
      if (!p_sclk && sclk && (!cs_ecg_n || !cs_imp_n)) begin
        sh = {sh[14:0], mosi}; nbit++;
      end
      if ((!p_ce && cs_ecg_n) || (!p_ci && cs_imp_n)) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected frame", int'(sh), 0);
        end else begin
          e = exp_q.pop_front();
          check(nbit == 16, e.tag, "R2 sclk count", nbit, 16);
          check(e.imp == !p_ci, e.tag, "R3 channel order", int'(!p_ci), int'(e.imp));
          check(sh == e.word, e.tag, "R5 word", int'(sh), int'(e.word));
        end
      end
    end
    p_sclk = sclk; p_ce = cs_ecg_n; p_ci = cs_imp_n;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(cs_ecg_n && cs_imp_n && !sclk && !mosi, "R1", "reset outputs",
          {cs_ecg_n, cs_imp_n, sclk, mosi}, 4'b1100);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(cs_ecg_n && cs_imp_n && !sclk && !mosi, "R1", "idle outputs",
          {cs_ecg_n, cs_imp_n, sclk, mosi}, 4'b1100);

    repeat (3) do_tick("R4");
    pulse_evt(1, 0, 0);
    repeat (ECG_LEN + 2) do_tick("R6");
    pulse_evt(0, 1, 0);
    repeat (ECG_LEN + 2) do_tick("R7");
    pulse_evt(0, 0, 1);
    repeat (IMP_LEN + 2) do_tick("R8");
    pulse_evt(1, 0, 0);
    repeat (3) do_tick("R9");
    pulse_evt(1, 0, 0);
    repeat (ECG_LEN + 1) do_tick("R9");
    pulse_evt(1, 1, 0);
    repeat (ECG_LEN + 1) do_tick("R10");
    do_tick("R11", 0, 0, 1);
    repeat (3) do_tick("R11");
    do_tick("R11", 1, 0, 0);
    repeat (IMP_LEN) do_tick("R11");
    pulse_evt(0, 0, 1);
    repeat (2) do_tick("R12");
    pulse_evt(0, 1, 0);
    repeat (IMP_LEN + 1) do_tick("R12");

    repeat (GAP) @(negedge clk);
    check(exp_q.size() == 0, "R3", "frames missing", exp_q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule